// File: doc/BRIEF.md
# LSB-Justified Audio Serial Transmitter/Receiver with Half-Word Packing

This block is the serial engine of a stereo audio port that runs as clock master. It divides the system clock down to a bit clock `ck`. It frames a left slot and then a right slot, each 32 bit clocks wide, and marks the slot with a word-select line `ws`. Samples are placed in LSB-justified form: the sample bits end exactly at the last bit of the slot, and the unused upper part of the slot is filled with zeros. Bits go out on `sd_out`, most significant bit first, and come in on `sd_in`. A sample is either 24 bits wide or 16 bits wide, and the 16-bit sample is zero-extended to the 32-bit slot.

Software reaches the block through a 16-bit data port with one flag per direction. On the transmit side, `txe` means a write is accepted. On the receive side, `rxne` means a read returns data. A 24-bit sample takes two ordered half-word accesses. The first access carries bits 23:16 in its low byte: on a write the high byte is don't-care, and on a read the high byte is 0x00. The second access carries bits 15:0. For example, 0x3478AE travels as 0x0034 and then 0x78AE. A 16-bit sample, such as 0x76A3, takes a single access.

Three state machines do the work. The framer has the states IDLE, LEFT and RIGHT. It leaves IDLE on the first falling edge of `ck` and then alternates LEFT and RIGHT at the falling edge that begins each slot. The transmit packer has the states FIRST, SECOND and FULL. A first write in 24-bit mode moves FIRST to SECOND, a 16-bit write moves FIRST to FULL, and a second write moves SECOND to FULL. A slot load moves FULL back to FIRST. The receive unpacker has the states EMPTY, FIRST, SECOND and ONLY. A slot arrival moves EMPTY to FIRST (24-bit) or to ONLY (16-bit). Reads move FIRST to SECOND, SECOND to EMPTY and ONLY to EMPTY.

Top module: `lsbj_audio_serdes`

## Requirements
- R1: While `enable` is high, `ck` has a period of CLK_DIV system clocks, with CLK_DIV/2 cycles high and CLK_DIV/2 cycles low. CLK_DIV must be even and at least 2.
- R2: `ws` is 0 for the whole left slot and 1 for the whole right slot, and each slot is 32 bit clocks long. `ws` and `sd_out` change only on the falling edge of `ck`.
- R3: In 16-bit mode (`mode_24`=0), each slot carries 16 zero bits and then the 16-bit sample, most significant bit first.
- R4: In 24-bit mode (`mode_24`=1), each slot carries 8 zero bits and then the 24-bit sample, most significant bit first.
- R5: In 24-bit mode, the first accepted write loads sample bits 23:16 from `wr_data[7:0]`, ignores `wr_data[15:8]`, and leaves `txe` at 1. The second accepted write loads bits 15:0 and drops `txe` to 0.
- R6: In 16-bit mode, one accepted write loads the whole sample and drops `txe` to 0.
- R7: A write while `txe` is 0 has no effect on the transmitted data.
- R8: In 24-bit mode, the first read returns {8'h00, bits 23:16} and the second read returns bits 15:0. `rxne` stays 1 between the two reads and falls after the second.
- R9: In 16-bit mode, one read returns the sample and clears `rxne`.
- R10: The receiver samples `sd_in` on the rising edges of `ck`, and a word is delivered at the rising edge of the slot's last bit. `rx_chan` gives the slot of the word being read (0 for left). `tx_chan` gives the slot that the sample being written will be loaded into.
- R11: When a slot starts and the transmit sample is not complete, `underrun` is set and stays set, and the slot carries all zeros. A write that completes in the load cycle is kept for the following slot.
- R12: When a word arrives and the receive register is not empty, `overrun` is set and stays set, and the new word is dropped. If a read empties the register in the arrival cycle, the word is accepted and no overrun is flagged.
- R13: While `enable` is low, `ck`, `ws`, `sd_out`, `underrun`, `overrun` and `rxne` are 0, and `txe` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the engine; low clears all state |
| mode_24 | input | 1 | 1 selects 24-bit samples, 0 selects 16-bit samples |
| wr_en | input | 1 | Write strobe for the transmit data port |
| wr_data | input | 16 | Transmit half-word |
| txe | output | 1 | Transmit port accepts a write |
| tx_chan | output | 1 | Slot of the sample being written (0 left, 1 right) |
| underrun | output | 1 | Sticky: a slot started without a complete sample |
| rd_en | input | 1 | Read strobe for the receive data port |
| rd_data | output | 16 | Receive half-word |
| rxne | output | 1 | Receive port holds data |
| rx_chan | output | 1 | Slot of the word being read (0 left, 1 right) |
| overrun | output | 1 | Sticky: a received word was dropped |
| ck | output | 1 | Bit clock |
| ws | output | 1 | Word select, 0 for left and 1 for right |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |

## Verification
Two pairs of functions can fall in the same cycle. On the transmit side, the write that completes a sample can land on the clock edge that loads a slot. On the receive side, the read that empties the register can land on the edge that delivers a new word. The bench locates the load edge from the rise of `ws`, and the arrival edge from the rise of `rxne`. It then places the single access one cycle before, exactly on, and one cycle after the next such edge. The outcome is judged at the ports two cycles later: `txe` must be 1 only when the write came before the load, and `rxne` and `overrun` must show that the word was accepted whenever the read came no later than the arrival. All other traffic runs through a loopback from `sd_out` to `sd_in`. Every slot is compared as a whole against its expected zero-padded image.

// File: rtl/lsbj_pkg.sv
package lsbj_pkg;

    localparam int SLOT_BITS = 32;
    localparam int HALF_W    = 16;
    localparam int LONG_W    = 24;
    localparam int HI_W      = LONG_W - HALF_W;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_LEFT,
        FR_RIGHT
    } frame_state_t;

    typedef enum logic [1:0] {
        TXQ_FIRST,
        TXQ_SECOND,
        TXQ_FULL
    } txq_state_t;

    typedef enum logic [1:0] {
        RXQ_EMPTY,
        RXQ_FIRST,
        RXQ_SECOND,
        RXQ_ONLY
    } rxq_state_t;

endpackage

// File: rtl/lsbj_bitclk.sv
module lsbj_bitclk #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ck,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    generate
        if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
            $error("CLK_DIV must be even and at least 2");
        end
    endgenerate

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ck  <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            ck  <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            ck  <= ~ck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobes mark the system clock edge on which ck changes.
    assign rise_stb = run && wrap && !ck;
    assign fall_stb = run && wrap && ck;

endmodule

// File: rtl/lsbj_framer.sv
module lsbj_framer
    import lsbj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise_stb,
    input  logic fall_stb,
    output logic ws,
    output logic load_stb,
    output logic load_right,
    output logic slot_end,
    output logic slot_right
);
    localparam int PW = $clog2(SLOT_BITS);

    frame_state_t state, state_nxt;
    logic [PW-1:0] pos;
    logic          last;

    assign last = (pos == PW'(SLOT_BITS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= FR_IDLE;
        else if (!run)   state <= FR_IDLE;
        else             state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            FR_IDLE:  if (fall_stb)         state_nxt = FR_LEFT;
            FR_LEFT:  if (fall_stb && last) state_nxt = FR_RIGHT;
            FR_RIGHT: if (fall_stb && last) state_nxt = FR_LEFT;
            default:                        state_nxt = FR_IDLE;
        endcase
    end

    // Bit position inside the slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (!run) begin
            pos <= '0;
        end else if (fall_stb) begin
            if (state == FR_IDLE || last) pos <= '0;
            else                          pos <= pos + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ws         = (state == FR_RIGHT);
        load_stb   = fall_stb && (state == FR_IDLE || last);
        load_right = (state == FR_LEFT);
        slot_end   = rise_stb && (state != FR_IDLE) && last;
        slot_right = (state == FR_RIGHT);
    end

endmodule

// File: rtl/lsbj_tx.sv
module lsbj_tx
    import lsbj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mode_24,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              fall_stb,
    input  logic              load_stb,
    output logic              txe,
    output logic              tx_chan,
    output logic              underrun,
    output logic              sd_out
);
    txq_state_t state, state_nxt;
    logic [LONG_W-1:0]    hold;
    logic [SLOT_BITS-1:0] shreg;
    logic [SLOT_BITS-1:0] image;
    logic                 take;
    logic                 consume;

    assign take    = wr_en && (state != TXQ_FULL);
    assign consume = load_stb && (state == TXQ_FULL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= TXQ_FIRST;
        else if (!run) state <= TXQ_FIRST;
        else           state <= state_nxt;
    end

    // Next state: a slot load is judged on the state before this edge
    always_comb begin
        state_nxt = state;
        unique case (state)
            TXQ_FULL:   if (load_stb) state_nxt = TXQ_FIRST;
            TXQ_FIRST:  if (wr_en)    state_nxt = mode_24 ? TXQ_SECOND : TXQ_FULL;
            TXQ_SECOND: if (wr_en)    state_nxt = TXQ_FULL;
            default:                  state_nxt = TXQ_FIRST;
        endcase
    end

    // Half-word packing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (take) begin
            if (state == TXQ_FIRST && mode_24)
                hold[LONG_W-1:HALF_W] <= wr_data[HI_W-1:0];
            else
                hold[HALF_W-1:0] <= wr_data;
        end
    end

    assign image = mode_24 ? SLOT_BITS'(hold) : SLOT_BITS'(hold[HALF_W-1:0]);

    // Outputs: shifter, channel pointer, sticky underrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            tx_chan  <= 1'b0;
            underrun <= 1'b0;
        end else if (!run) begin
            shreg    <= '0;
            tx_chan  <= 1'b0;
            underrun <= 1'b0;
        end else if (load_stb) begin
            shreg   <= consume ? image : '0;
            tx_chan <= ~tx_chan;
            if (!consume) underrun <= 1'b1;
        end else if (fall_stb) begin
            shreg <= {shreg[SLOT_BITS-2:0], 1'b0};
        end
    end

    assign sd_out = shreg[SLOT_BITS-1];
    assign txe    = (state != TXQ_FULL);

endmodule

// File: rtl/lsbj_rx.sv
module lsbj_rx
    import lsbj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mode_24,
    input  logic              rd_en,
    input  logic              sd_in,
    input  logic              rise_stb,
    input  logic              slot_end,
    input  logic              slot_right,
    output logic [HALF_W-1:0] rd_data,
    output logic              rxne,
    output logic              rx_chan,
    output logic              overrun
);
    rxq_state_t state, after_rd, state_nxt;
    logic [SLOT_BITS-2:0] shreg;
    logic [SLOT_BITS-1:0] word;
    logic [LONG_W-1:0]    hold;
    logic                 pop;
    logic                 accept;

    assign pop    = rd_en && (state != RXQ_EMPTY);
    assign word   = {shreg, sd_in};

    // Effect of a read alone
    always_comb begin
        after_rd = state;
        unique case (state)
            RXQ_EMPTY:  after_rd = RXQ_EMPTY;
            RXQ_FIRST:  if (pop) after_rd = RXQ_SECOND;
            RXQ_SECOND: if (pop) after_rd = RXQ_EMPTY;
            RXQ_ONLY:   if (pop) after_rd = RXQ_EMPTY;
            default:             after_rd = RXQ_EMPTY;
        endcase
    end

    // A read that empties the register in the arrival cycle frees it
    assign accept = slot_end && (after_rd == RXQ_EMPTY);

    always_comb begin
        state_nxt = after_rd;
        if (accept) state_nxt = mode_24 ? RXQ_FIRST : RXQ_ONLY;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= RXQ_EMPTY;
        else if (!run) state <= RXQ_EMPTY;
        else           state <= state_nxt;
    end

    // Deserialiser
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        shreg <= '0;
        else if (rise_stb) shreg <= word[SLOT_BITS-2:0];
    end

    // Captured word, channel, sticky overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold    <= '0;
            rx_chan <= 1'b0;
            overrun <= 1'b0;
        end else if (!run) begin
            rx_chan <= 1'b0;
            overrun <= 1'b0;
        end else if (accept) begin
            hold    <= mode_24 ? word[LONG_W-1:0] : LONG_W'(word[HALF_W-1:0]);
            rx_chan <= slot_right;
        end else if (slot_end) begin
            overrun <= 1'b1;
        end
    end

    // Read port
    always_comb begin
        unique case (state)
            RXQ_FIRST:  rd_data = HALF_W'(hold[LONG_W-1:HALF_W]);
            RXQ_SECOND: rd_data = hold[HALF_W-1:0];
            RXQ_ONLY:   rd_data = hold[HALF_W-1:0];
            default:    rd_data = '0;
        endcase
    end

    assign rxne = (state != RXQ_EMPTY);

endmodule

// File: rtl/lsbj_audio_serdes.sv
module lsbj_audio_serdes
    import lsbj_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mode_24,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_data,
    output logic              txe,
    output logic              tx_chan,
    output logic              underrun,
    input  logic              rd_en,
    output logic [HALF_W-1:0] rd_data,
    output logic              rxne,
    output logic              rx_chan,
    output logic              overrun,
    output logic              ck,
    output logic              ws,
    output logic              sd_out,
    input  logic              sd_in
);
    logic rise_stb;
    logic fall_stb;
    logic load_stb;
    logic load_right;
    logic slot_end;
    logic slot_right;

    lsbj_bitclk #(.CLK_DIV(CLK_DIV)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .ck       (ck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    lsbj_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .rise_stb   (rise_stb),
        .fall_stb   (fall_stb),
        .ws         (ws),
        .load_stb   (load_stb),
        .load_right (load_right),
        .slot_end   (slot_end),
        .slot_right (slot_right)
    );

    lsbj_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .mode_24  (mode_24),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .fall_stb (fall_stb),
        .load_stb (load_stb),
        .txe      (txe),
        .tx_chan  (tx_chan),
        .underrun (underrun),
        .sd_out   (sd_out)
    );

    lsbj_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .mode_24    (mode_24),
        .rd_en      (rd_en),
        .sd_in      (sd_in),
        .rise_stb   (rise_stb),
        .slot_end   (slot_end),
        .slot_right (slot_right),
        .rd_data    (rd_data),
        .rxne       (rxne),
        .rx_chan    (rx_chan),
        .overrun    (overrun)
    );

endmodule

// File: rtl/lsbj_checker.sv
module lsbj_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic mode_24,
    input logic wr_en,
    input logic txe,
    input logic rxne,
    input logic ck,
    input logic ws,
    input logic sd_out,
    input logic underrun,
    input logic overrun,
    input logic load_stb,
    input logic load_right,
    input logic tx_chan
);
    // R13: a disabled engine is quiet and cleared
    a_r13_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ck && !ws && !sd_out && !underrun && !overrun && !rxne && txe));

    // R2: word select moves only with a falling bit clock
    a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !$stable(ws)) |-> $fell(ck));

    // R2: serial data moves only with a falling bit clock
    a_r2_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !$stable(sd_out)) |-> $fell(ck));

    // R11: underrun stays set while running
    a_r11_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && underrun) |=> (underrun || !enable));

    // R12: overrun stays set while running
    a_r12_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && overrun) |=> (overrun || !enable));

    // R10: the channel pointer agrees with the slot the framer loads
    a_r10_chan_match: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (tx_chan == load_right));

    // R6: one accepted 16-bit write fills the transmit register
    a_r6_single_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr_en && txe && !mode_24) |=> (!txe || !enable));

endmodule

bind lsbj_audio_serdes lsbj_checker u_lsbj_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .mode_24    (mode_24),
    .wr_en      (wr_en),
    .txe        (txe),
    .rxne       (rxne),
    .ck         (ck),
    .ws         (ws),
    .sd_out     (sd_out),
    .underrun   (underrun),
    .overrun    (overrun),
    .load_stb   (load_stb),
    .load_right (load_right),
    .tx_chan    (tx_chan)
);

// File: tb/test_lsbj_audio_serdes.sv
module test_lsbj_audio_serdes;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        mode_24 = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        txe, tx_chan, underrun, rxne, rx_chan, overrun, ck, ws, sd_out;
    logic [15:0] rd_data;

    int vecs = 0;
    int errs = 0;

    // 50 MHz system clock: 20 time units per period
    always #10 clk = ~clk;

    lsbj_audio_serdes #(.CLK_DIV(DIV)) i_lsbj_audio_serdes (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_24(mode_24),
        .wr_en(wr_en), .wr_data(wr_data), .txe(txe), .tx_chan(tx_chan),
        .underrun(underrun), .rd_en(rd_en), .rd_data(rd_data), .rxne(rxne),
        .rx_chan(rx_chan), .overrun(overrun), .ck(ck), .ws(ws),
        .sd_out(sd_out), .sd_in(sd_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] samp(input bit m24, input int i);
        int w;
        logic [23:0] mask;
        w    = m24 ? 24 : 16;
        mask = m24 ? 24'hFFFFFF : 24'h00FFFF;
        if (i == 0)     return m24 ? 24'h3478AE : 24'h0076A3;
        if (i <= w)     return 24'h000001 << (i - 1);
        if (i == w + 1) return mask;
        if (i == w + 2) return 24'h000000;
        return 24'(i * 32'h009E3779 + 32'h5A5) & mask;
    endfunction

    // Serial monitor: whole-slot images, bit by bit, MSB first
    logic [31:0] img_q[$];
    logic [23:0] smp_q[$];
    bit          mon_on = 1'b0;
    bit          mon_go = 1'b0;
    int          mon_idx = 0;
    logic [31:0] cur_img = '0;
    logic [31:0] cap = '0;
    bit          ws_bad = 1'b0;

    always @(negedge ck) if (mon_on) mon_go = 1'b1;

    always @(posedge ck) begin
        if (mon_on && mon_go) begin
            if (mon_idx % 32 == 0) begin
                cur_img = (img_q.size() > 0) ? img_q.pop_front() : 32'h0;
                cap     = '0;
                ws_bad  = 1'b0;
            end
            cap = {cap[30:0], sd_out};
            if (ws !== 1'((mon_idx / 32) % 2)) ws_bad = 1'b1;
            if (mon_idx % 32 == 31) begin
                chk(cap == cur_img, mode_24 ? "R4 slot image" : "R3 slot image", cap, cur_img);
                chk(!ws_bad, "R2 ws level in slot", 32'(ws_bad), 32'h0);
            end
            mon_idx++;
        end
    end

    task automatic writer(input bit m24, input int n);
        logic [23:0] s;
        for (int i = 0; i < n; i++) begin
            s = samp(m24, i);
            do @(negedge clk); while (!txe);
            chk(tx_chan == i[0], "R10 tx_chan", 32'(tx_chan), 32'(i[0]));
            wr_en = 1'b1;
            if (m24) begin
                wr_data = {8'hA5 ^ 8'(i), s[23:16]};
                @(negedge clk);
                chk(txe == 1'b1, "R5 txe after first write", 32'(txe), 32'h1);
                wr_data = s[15:0];
                @(negedge clk);
                chk(txe == 1'b0, "R5 txe after second write", 32'(txe), 32'h0);
            end else begin
                wr_data = s[15:0];
                @(negedge clk);
                chk(txe == 1'b0, "R6 txe after write", 32'(txe), 32'h0);
            end
            img_q.push_back(m24 ? {8'h00, s} : {16'h0000, s[15:0]});
            smp_q.push_back(s);
            // R7: extra write while full must not reach the line
            wr_data = 16'hDEAD;
            @(negedge clk);
            wr_en = 1'b0;
        end
        chk(underrun == 1'b0, "R11 no underrun while fed", 32'(underrun), 32'h0);
    endtask

    task automatic reader(input bit m24, input int n);
        logic [23:0] s;
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!rxne);
            s = smp_q.pop_front();
            chk(rx_chan == i[0], "R10 rx_chan", 32'(rx_chan), 32'(i[0]));
            if (m24) begin
                chk(rd_data == {8'h00, s[23:16]}, "R8 first read", 32'(rd_data), 32'({8'h00, s[23:16]}));
                rd_en = 1'b1;
                @(negedge clk);
                chk(rxne == 1'b1, "R8 rxne between reads", 32'(rxne), 32'h1);
                chk(rd_data == s[15:0], "R8 second read", 32'(rd_data), 32'(s[15:0]));
                @(negedge clk);
                rd_en = 1'b0;
                chk(rxne == 1'b0, "R8 rxne after reads", 32'(rxne), 32'h0);
            end else begin
                chk(rd_data == s[15:0], "R9 read", 32'(rd_data), 32'(s[15:0]));
                rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0;
                chk(rxne == 1'b0, "R9 rxne after read", 32'(rxne), 32'h0);
            end
        end
        chk(overrun == 1'b0, "R12 no overrun while drained", 32'(overrun), 32'h0);
    endtask

    task automatic measure_ck();
        int hi = 0;
        int lo = 0;
        do @(negedge clk); while (ck);
        do @(negedge clk); while (!ck);
        while (ck)  begin hi++; @(negedge clk); end
        while (!ck) begin lo++; @(negedge clk); end
        chk(hi == DIV / 2, "R1 ck high time", 32'(hi), 32'(DIV / 2));
        chk(lo == DIV / 2, "R1 ck low time", 32'(lo), 32'(DIV / 2));
    endtask

    task automatic stop_engine();
        mon_on = 1'b0;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!underrun && !overrun && !rxne && txe && !ck && !ws,
            "R13 cleared when disabled",
            {26'h0, underrun, overrun, rxne, txe, ck, ws}, 32'h4);
        mon_go  = 1'b0;
        mon_idx = 0;
        img_q.delete();
        smp_q.delete();
    endtask

    task automatic run_stream(input bit m24);
        int n;
        n = (m24 ? 24 : 16) + 6;
        mode_24 = m24;
        mon_on  = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        fork
            writer(m24, n);
            reader(m24, n);
            measure_ck();
        join
        repeat (300) @(negedge clk);
        chk(underrun == 1'b1, "R11 underrun once starved", 32'(underrun), 32'h1);
        chk(overrun == 1'b1, "R12 overrun once not drained", 32'(overrun), 32'h1);
        stop_engine();
    endtask

    // Write lands one cycle before, on, or after a slot load edge
    task automatic tx_trial(input int k);
        mode_24 = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        do @(negedge clk); while (!ws);
        repeat (127 + k) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (1 - k) @(negedge clk);
        chk(txe == (k < 0), $sformatf("R11 txe write offset %0d", k), 32'(txe), 32'(k < 0));
        chk(underrun == 1'b1, "R11 underrun on empty slots", 32'(underrun), 32'h1);
        stop_engine();
    endtask

    // Final read lands one cycle before, on, or after a word arrival
    task automatic rx_trial(input int k);
        mode_24 = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        do @(negedge clk); while (!rxne);
        repeat (127 + k) @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        repeat (2 - k) @(negedge clk);
        chk(rxne == (k <= 0), $sformatf("R12 rxne read offset %0d", k), 32'(rxne), 32'(k <= 0));
        chk(overrun == (k > 0), $sformatf("R12 overrun read offset %0d", k), 32'(overrun), 32'(k > 0));
        stop_engine();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txe && !rxne && !ck && !ws && !sd_out && !underrun && !overrun && !tx_chan && rd_data == 16'h0,
            "R13 reset state",
            {txe, rxne, ck, ws, sd_out, underrun, overrun, tx_chan, 8'h0, rd_data}, 32'h80000000);
        run_stream(1'b1);
        run_stream(1'b0);
        for (int k = -1; k <= 1; k++) tx_trial(k);
        for (int k = -1; k <= 1; k++) rx_trial(k);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule